// File: doc/BRIEF.md
# Chained Array-Synchronized DMA Engine

This block is a small multi-channel copy engine. Each channel keeps its own set of transfer parameters: a source address, a destination address, an array length in bytes (`ACNT`), an array count per frame (`BCNT`), a frame count (`CCNT`), and an option word. Software loads a parameter set through the configuration pins. It then starts the channel by writing a one to that channel's bit of `evt_set`. Each synchronization event moves one slice of the block. In array mode the slice is one array of `ACNT` contiguous bytes. In frame mode the slice is a whole frame of `ACNT*BCNT` bytes. Both addresses advance past the slice once it has been copied.

When a slice finishes, the engine can do two things, each selected by an option bit:
- raise a new synchronization event on the channel named by the completion code;
- set a sticky interrupt bit indexed by that code.

Intermediate slices and the final slice have separate enables. A channel whose completion code is its own number therefore walks through a large block one slice at a time. Each chained event goes back through the same pending register and round-robin arbiter as software events, so other channels can take turns between the slices.

Data moves through three valid/ready channels: a read request, a read response and a write. One byte is in flight at a time. Memory stalls the engine by holding a `ready` low, and the engine keeps its address and data stable while it waits.

Top module: `achain_dma`

## Requirements
- R1: After reset, `busy`, `evt_pend`, `int_pend`, `err_pend`, `rd_valid` and `wr_valid` are all zero.
- R2: A one on `evt_set[N]` for an active channel sets `evt_pend[N]` on the next clock edge. The bit clears on the edge where that channel's slice starts. `busy` is high from that edge until the slice's last byte is written.
- R3: In array mode (option bit 0 clear), each event copies exactly `ACNT` bytes from consecutive source addresses to consecutive destination addresses. Both addresses then advance by `ACNT`.
- R4: In frame mode (option bit 0 set), each event copies one whole frame of `ACNT*BCNT` bytes.
- R5: A channel becomes inactive once all `BCNT*CCNT` arrays are done, or when it is loaded with any zero count. An event on an inactive channel moves no data and sets `err_pend[N]`.
- R6: With option bit 3 set, finishing any slice other than the last raises an event on the channel numbered by the completion code (option bits 5 and up).
- R7: With option bit 4 set, finishing the last slice raises an event on the channel numbered by the completion code.
- R8: Finishing the last slice with option bit 2 set, or an earlier slice with option bit 1 set, sets `int_pend[code]`. No interrupt bit is set otherwise. Interrupt bits stay set until cleared by a one on `int_clr`.
- R9: Pending channels are served round-robin. When two self-chained channels are both pending, their slices alternate.
- R10: `rd_valid` and `wr_valid`, together with their address and data, are held stable until the matching ready is seen. Only one byte is in flight at a time.
- R11: `err_pend` bits stay set until cleared by a one on `err_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the parameter set of `cfg_ch` |
| cfg_ch | input | CHW | Channel being loaded |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_acnt | input | ACW | Bytes per array |
| cfg_bcnt | input | BCW | Arrays per frame |
| cfg_ccnt | input | CCW | Frames |
| cfg_opt | input | OPTW | Option word: [0] frame mode, [1] intermediate interrupt, [2] final interrupt, [3] intermediate chain, [4] final chain, [5+] completion code |
| evt_set | input | NCH | Write-one event request per channel |
| evt_pend | output | NCH | Pending events |
| int_clr | input | NCH | Write-one clear of interrupt bits |
| int_pend | output | NCH | Sticky interrupt bits, indexed by completion code |
| err_clr | input | NCH | Write-one clear of error bits |
| err_pend | output | NCH | Sticky error bits: event on an inactive channel |
| busy | output | 1 | A slice is being copied |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Engine accepts read data |
| rsp_data | input | 8 | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data |

## Verification
The assertions assume the memory side behaves as follows:
- A read response arrives only after a read request has been accepted.
- A parameter set is never reloaded while its channel is mid-slice.
- `int_clr` and `err_clr` are pulsed only by software.

The bench keeps to these rules. It loads a channel only when the engine is idle and pending is empty, and its memory model raises `rsp_valid` only after it has captured a read request. Its ready and response timing is drawn from a fixed-seed random source, so back-pressure lands on every phase of a byte.

// File: rtl/achain_pkg.sv
package achain_pkg;
  localparam int OPT_SYNC_AB   = 0;
  localparam int OPT_ITC_INT   = 1;
  localparam int OPT_TC_INT    = 2;
  localparam int OPT_ITC_CHAIN = 3;
  localparam int OPT_TC_CHAIN  = 4;
  localparam int OPT_TCC_LSB   = 5;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_RSP, MV_WR} mv_state_e;
endpackage

// File: rtl/achain_rr.sv
module achain_rr #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr_q;
  int t;

  // search starts just after the last winner; nearest requester wins
  always_comb begin
    grant = '0;
    idx   = '0;
    t     = 0;
    for (int k = N; k >= 1; k--) begin
      t = int'(ptr_q) + k;
      if (t >= N) t = t - N;
      if (req[t[IW-1:0]]) begin
        grant = N'(1) << t[IW-1:0];
        idx   = t[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else if (take) ptr_q <= idx;
  end

  assert_grant_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($onehot(grant) && ((grant & ~req) == '0)));
endmodule

// File: rtl/achain_mover.sv
module achain_mover
  import achain_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          done,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  mv_state_e     st_q;
  logic [AW-1:0] ra_q, wa_q;
  logic [LW-1:0] left_q;
  logic [7:0]    data_q;

  assign busy      = (st_q != MV_IDLE);
  assign rd_valid  = (st_q == MV_RD);
  assign rsp_ready = (st_q == MV_RSP);
  assign wr_valid  = (st_q == MV_WR);
  assign rd_addr   = ra_q;
  assign wr_addr   = wa_q;
  assign wr_data   = data_q;
  assign done      = wr_valid && wr_ready && (left_q == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      ra_q   <= '0;
      wa_q   <= '0;
      left_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        MV_IDLE: if (start) begin
          ra_q   <= src;
          wa_q   <= dst;
          left_q <= len;
          st_q   <= MV_RD;
        end
        MV_RD:  if (rd_ready) st_q <= MV_RSP;
        MV_RSP: if (rsp_valid) begin
          data_q <= rsp_data;
          st_q   <= MV_WR;
        end
        MV_WR:  if (wr_ready) begin
          ra_q   <= ra_q + AW'(1);
          wa_q   <= wa_q + AW'(1);
          left_q <= left_q - LW'(1);
          st_q   <= (left_q == LW'(1)) ? MV_IDLE : MV_RD;
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_len_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0));
endmodule

// File: rtl/achain_dma.sv
module achain_dma
  import achain_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int ACW = 8,
  parameter int BCW = 4,
  parameter int CCW = 4,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OPTW = OPT_TCC_LSB + CHW,
  localparam int LW   = ACW + BCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [ACW-1:0]  cfg_acnt,
  input  logic [BCW-1:0]  cfg_bcnt,
  input  logic [CCW-1:0]  cfg_ccnt,
  input  logic [OPTW-1:0] cfg_opt,
  input  logic [NCH-1:0]  evt_set,
  output logic [NCH-1:0]  evt_pend,
  input  logic [NCH-1:0]  int_clr,
  output logic [NCH-1:0]  int_pend,
  input  logic [NCH-1:0]  err_clr,
  output logic [NCH-1:0]  err_pend,
  output logic            busy,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [7:0]      rsp_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [7:0]      wr_data
);
  logic [AW-1:0]   src_q  [NCH];
  logic [AW-1:0]   dst_q  [NCH];
  logic [ACW-1:0]  acnt_q [NCH];
  logic [BCW-1:0]  bcnt_q [NCH];
  logic [BCW-1:0]  brl_q  [NCH];
  logic [CCW-1:0]  ccnt_q [NCH];
  logic [OPTW-1:0] opt_q  [NCH];
  logic [NCH-1:0]  act_q, pend_q, err_q, int_q;
  logic [CHW-1:0]  cur_q;

  logic            mv_busy, mv_done, start;
  logic [NCH-1:0]  grant;
  logic [CHW-1:0]  gidx;
  logic [LW-1:0]   start_len, done_len;
  logic [OPTW-1:0] cur_opt;
  logic            last_w;
  logic [CHW-1:0]  tcc_w;
  logic [NCH-1:0]  chain_vec, int_vec, act_next, evt_all, evt_ok, evt_bad;

  function automatic logic [LW-1:0] span(input logic ab, input logic [ACW-1:0] a,
                                         input logic [BCW-1:0] b);
    return ab ? LW'(a) * LW'(b) : LW'(a);
  endfunction

  assign cur_opt   = opt_q[cur_q];
  assign start     = !mv_busy && (pend_q != '0);
  assign start_len = span(opt_q[gidx][OPT_SYNC_AB], acnt_q[gidx], bcnt_q[gidx]);
  assign done_len  = span(cur_opt[OPT_SYNC_AB], acnt_q[cur_q], bcnt_q[cur_q]);

  always_comb begin
    last_w = cur_opt[OPT_SYNC_AB] ? (ccnt_q[cur_q] == CCW'(1))
           : ((bcnt_q[cur_q] == BCW'(1)) && (ccnt_q[cur_q] == CCW'(1)));
    tcc_w  = cur_opt[OPT_TCC_LSB +: CHW];
    chain_vec = (mv_done && (last_w ? cur_opt[OPT_TC_CHAIN] : cur_opt[OPT_ITC_CHAIN]))
              ? (NCH'(1) << tcc_w) : '0;
    int_vec   = (mv_done && (last_w ? cur_opt[OPT_TC_INT] : cur_opt[OPT_ITC_INT]))
              ? (NCH'(1) << tcc_w) : '0;
    act_next = act_q;
    if (mv_done && last_w) act_next[cur_q] = 1'b0;
    if (cfg_we) act_next[cfg_ch] = (cfg_acnt != '0) && (cfg_bcnt != '0) && (cfg_ccnt != '0);
    evt_all = evt_set | chain_vec;
    evt_ok  = evt_all & act_next;
    evt_bad = evt_all & ~act_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        acnt_q[i] <= '0;
        bcnt_q[i] <= '0;
        brl_q[i]  <= '0;
        ccnt_q[i] <= '0;
        opt_q[i]  <= '0;
      end
      act_q  <= '0;
      pend_q <= '0;
      err_q  <= '0;
      int_q  <= '0;
      cur_q  <= '0;
    end else begin
      act_q  <= act_next;
      pend_q <= ((pend_q & ~(start ? grant : '0)) | evt_ok) & act_next;
      err_q  <= (err_q & ~err_clr) | evt_bad;
      int_q  <= (int_q & ~int_clr) | int_vec;
      if (start) cur_q <= gidx;
      if (mv_done) begin
        src_q[cur_q] <= src_q[cur_q] + AW'(done_len);
        dst_q[cur_q] <= dst_q[cur_q] + AW'(done_len);
        if (cur_opt[OPT_SYNC_AB] || (bcnt_q[cur_q] == BCW'(1))) begin
          bcnt_q[cur_q] <= brl_q[cur_q];
          ccnt_q[cur_q] <= ccnt_q[cur_q] - CCW'(1);
        end else begin
          bcnt_q[cur_q] <= bcnt_q[cur_q] - BCW'(1);
        end
      end
      if (cfg_we) begin
        src_q[cfg_ch]  <= cfg_src;
        dst_q[cfg_ch]  <= cfg_dst;
        acnt_q[cfg_ch] <= cfg_acnt;
        bcnt_q[cfg_ch] <= cfg_bcnt;
        brl_q[cfg_ch]  <= cfg_bcnt;
        ccnt_q[cfg_ch] <= cfg_ccnt;
        opt_q[cfg_ch]  <= cfg_opt;
      end
    end
  end

  achain_rr #(.N(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend_q), .take(start), .grant(grant), .idx(gidx)
  );

  achain_mover #(.AW(AW), .LW(LW)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src(src_q[gidx]), .dst(dst_q[gidx]), .len(start_len),
    .busy(mv_busy), .done(mv_done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign evt_pend = pend_q;
  assign int_pend = int_q;
  assign err_pend = err_q;
  assign busy     = mv_busy;

  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ((evt_ok & grant) == '0)) |=> ((pend_q & $past(grant)) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_int_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_q[i]) |-> $past(int_clr[i]));
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_q[i]) |-> $past(err_clr[i]));
    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[i]) |-> $past(evt_set[i] | chain_vec[i]));
  end
endmodule

// File: tb/achain_dma_bench.sv
module achain_dma_bench;
  localparam int NCH = 4, AW = 12, ACW = 8, BCW = 4, CCW = 4, CHW = 2, OPTW = 7;
  localparam logic [6:0] O_AB = 7'd1, O_II = 7'd2, O_TI = 7'd4, O_IC = 7'd8, O_TC = 7'd16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [CHW-1:0]  cfg_ch = '0;
  logic [AW-1:0]   cfg_src = '0, cfg_dst = '0;
  logic [ACW-1:0]  cfg_acnt = '0;
  logic [BCW-1:0]  cfg_bcnt = '0;
  logic [CCW-1:0]  cfg_ccnt = '0;
  logic [OPTW-1:0] cfg_opt = '0;
  logic [NCH-1:0]  evt_set = '0, int_clr = '0, err_clr = '0;
  logic [NCH-1:0]  evt_pend, int_pend, err_pend;
  logic            busy, rd_valid, rd_ready, rsp_valid, rsp_ready, wr_valid, wr_ready;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [7:0]      rsp_data, wr_data;

  achain_dma u_achain_dma (.*);

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [7:0]    mem  [4096];
  logic [AW-1:0] wlog [1024];
  logic          ilog [1024];
  logic          rsp_pend;
  logic [AW-1:0] rsp_a;

  function automatic logic [7:0] img(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [6:0] tccv(input int c);
    return 7'(c << 5);
  endfunction

  // memory model: sources below 2048 come from img(), writes land in mem
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ready <= 1'b0; wr_ready <= 1'b0; rsp_valid <= 1'b0; rsp_pend <= 1'b0;
      rsp_a <= '0; rsp_data <= '0; wr_cnt <= 0;
    end else begin
      rd_ready <= ($urandom % 4) != 0;
      wr_ready <= ($urandom % 3) != 0;
      if (rd_valid && rd_ready) begin
        rsp_pend <= 1'b1;
        rsp_a    <= rd_addr;
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      else if (rsp_pend && !rsp_valid && ($urandom % 2 == 0)) begin
        rsp_valid <= 1'b1;
        rsp_data  <= (rsp_a < 2048) ? img(int'(rsp_a)) : mem[rsp_a];
        rsp_pend  <= 1'b0;
      end
      if (wr_valid && wr_ready) begin
        mem[wr_addr]       <= wr_data;
        wlog[wr_cnt % 1024] <= wr_addr;
        ilog[wr_cnt % 1024] <= |int_pend;
        wr_cnt             <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic cfg(input int ch, input int s, input int d, input int a, input int b,
                     input int c, input logic [6:0] o);
    @(negedge clk);
    cfg_ch = CHW'(ch); cfg_src = AW'(s); cfg_dst = AW'(d);
    cfg_acnt = ACW'(a); cfg_bcnt = BCW'(b); cfg_ccnt = CCW'(c); cfg_opt = o; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig(input logic [NCH-1:0] m);
    @(negedge clk); evt_set = m;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic clr_int(input logic [NCH-1:0] m);
    @(negedge clk); int_clr = m;
    @(negedge clk); int_clr = '0;
  endtask

  task automatic clr_err(input logic [NCH-1:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int n = 0;
    while (quiet < 4 && n < 20000) begin
      @(negedge clk);
      n++;
      if (!busy && evt_pend == '0) quiet++; else quiet = 0;
    end
    if (quiet < 4) chk("R10 idle timeout", 0, 1);
  endtask

  function automatic int mism(input int s, input int d, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[d + i] !== img(s + i)) bad++;
    return bad;
  endfunction

  initial begin
    repeat (50000 * 3) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 evt_pend", int'(evt_pend), 0);
    chk("R1 int_pend", int'(int_pend), 0);
    chk("R1 err_pend", int'(err_pend), 0);
    chk("R1 valids", int'({rd_valid, wr_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 self-chain through 4 arrays, final interrupt only (R8)
    cfg(0, 0, 2048, 8, 4, 1, O_IC | O_TI | tccv(0));
    base = wr_cnt;
    trig(4'b0001);
    wait_idle();
    chk("R6 self-chain bytes", wr_cnt - base, 32);
    chk("R3 content ch0", mism(0, 2048, 32), 0);
    chk("R8 final int", int'(int_pend), 1);
    begin
      int early = 0;
      for (int i = base; i < base + 32; i++) if (ilog[i % 1024]) early++;
      chk("R8 no intermediate int", early, 0);
    end
    clr_int(4'b0001);
    chk("R8 int w1c", int'(int_pend), 0);

    // R2/R3/R5 array mode without chaining: one array per event
    cfg(1, 100, 2304, 5, 2, 2, O_TI | tccv(1));
    base = wr_cnt;
    trig(4'b0010);
    chk("R2 pend set", int'(evt_pend), 2);
    @(negedge clk);
    chk("R2 pend cleared at start", int'(evt_pend), 0);
    chk("R2 busy", int'(busy), 1);
    wait_idle();
    chk("R3 one array", wr_cnt - base, 5);
    for (int k = 0; k < 2; k++) begin trig(4'b0010); wait_idle(); end
    chk("R8 no int before last", int'(int_pend), 0);
    trig(4'b0010);
    wait_idle();
    chk("R5 total arrays", wr_cnt - base, 20);
    chk("R3 content ch1", mism(100, 2304, 20), 0);
    chk("R8 int at last", int'(int_pend), 2);
    base = wr_cnt;
    trig(4'b0010);
    wait_idle();
    chk("R5 inactive moves nothing", wr_cnt - base, 0);
    chk("R5 err flag", int'(err_pend), 2);
    clr_err(4'b0010);
    chk("R11 err w1c", int'(err_pend), 0);
    clr_int(4'hF);

    // R4 frame mode
    cfg(2, 300, 2560, 3, 4, 2, O_AB | O_TI | tccv(2));
    base = wr_cnt;
    trig(4'b0100);
    wait_idle();
    chk("R4 one frame", wr_cnt - base, 12);
    chk("R4 no int yet", int'(int_pend), 0);
    trig(4'b0100);
    wait_idle();
    chk("R4 second frame", wr_cnt - base, 24);
    chk("R4 content", mism(300, 2560, 24), 0);
    chk("R8 frame int", int'(int_pend), 4);
    clr_int(4'hF);

    // R6 chain to another channel, intermediate interrupt on code 3
    cfg(0, 400, 2048, 2, 2, 1, O_IC | O_II | tccv(3));
    cfg(3, 500, 2816, 4, 1, 1, 7'd0);
    base = wr_cnt;
    trig(4'b0001);
    wait_idle();
    chk("R6 chain other bytes", wr_cnt - base, 6);
    chk("R6 chained content", mism(500, 2816, 4), 0);
    chk("R8 intermediate int", int'(int_pend), 8);
    base = wr_cnt;
    trig(4'b0001);
    wait_idle();
    chk("R6 last array no chain", wr_cnt - base, 2);
    chk("R6 no error on target", int'(err_pend), 0);
    chk("R3 content ch0 second", mism(400, 2048, 4), 0);
    clr_int(4'hF);

    // R7 final chaining
    cfg(1, 600, 2304, 3, 1, 1, O_TC | tccv(2));
    cfg(2, 700, 2560, 2, 1, 1, O_TI | tccv(2));
    base = wr_cnt;
    trig(4'b0010);
    wait_idle();
    chk("R7 final chain bytes", wr_cnt - base, 5);
    chk("R7 int from chained", int'(int_pend), 4);
    clr_int(4'hF);

    // R9 round-robin interleave of two self-chained channels
    cfg(1, 800, 2304, 3, 3, 1, O_IC | tccv(1));
    cfg(2, 900, 2560, 3, 3, 1, O_IC | tccv(2));
    base = wr_cnt;
    trig(4'b0110);
    wait_idle();
    chk("R9 total", wr_cnt - base, 18);
    begin
      int sw = 0;
      for (int i = base + 1; i < base + 18; i++)
        if ((wlog[i % 1024] >> 8) != (wlog[(i - 1) % 1024] >> 8)) sw++;
      chk("R9 alternation", sw, 5);
    end

    // R3 random shapes with self-chaining through frames
    for (int it = 0; it < 6; it++) begin
      int ch = int'($urandom % 4);
      int a  = 1 + int'($urandom % 20);
      int b  = 1 + int'($urandom % 4);
      int c  = 1 + int'($urandom % 3);
      int s  = 1000 + int'($urandom % 600);
      cfg(ch, s, 3072, a, b, c, O_IC | O_TI | tccv(ch));
      base = wr_cnt;
      trig(NCH'(1) << ch);
      wait_idle();
      chk("R3 random bytes", wr_cnt - base, a * b * c);
      chk("R3 random content", mism(s, 3072, a * b * c), 0);
      chk("R8 random int", int'(int_pend), 1 << ch);
      clr_int(4'hF);
    end

    summary();
    $finish;
  end
endmodule